// File: doc/BRIEF.md
# Serial Control and Fault Status Port

This block is the byte-wide serial slave of a LIN node support chip. Each transfer lasts as long as chip-select is held low. During it the host shifts in one control byte and shifts out one status byte at the same time. The control byte sets the LIN edge-rate selection, a low-power request, the LIN pull-up disconnect and three high-side switch enables. It also sets the two operating-mode bits.

The status byte is frozen when chip-select falls. It reports the latched fault flags and the two switch-sense inputs. Its top bit says how the rest of the byte should be read: the interrupt sources gathered since the last read, or the current flag state. Fault conditions arrive as synchronous digital inputs. A new fault raises a fixed-length low pulse on the interrupt output. A high-side thermal trip turns the affected switch off and keeps it off until software writes its enable bit as 1 again. The first two high-side outputs are additionally gated by a PWM input.

The serial pins are asynchronous to the system clock. They are synchronised, and their edges are detected in the clock domain.

Top module: `sbc_ctrl_port`

## Requirements
- R1: After reset the outputs take these values: `mode_bits` = 2'b11, `lin_slew` = 2'b00, `lowpwr_req` = 0, `lin_pullup_off` = 0, `hs_out` = 0, `irq_n` = 1 and `spi_miso` = 0.
- R2: A transfer counts only when exactly 8 SCLK falling edges occur while chip-select is low. The write byte is taken MSB first from `spi_mosi` on those falling edges and applied when chip-select rises. A transfer with any other edge count changes no control output and clears no flag.
- R3: The status byte is driven on `spi_miso` MSB first. Each bit is presented on an SCLK rising edge, so the host can sample it on the following falling edge.
- R4: The status byte is captured at the chip-select fall. Its layout is: bit7 = interrupt pending, bit6 = LIN event, bit5 = supply over-voltage, bit4 = supply under-voltage, bit3 = regulator temperature warning, bit2 = high-side thermal shutdown (any switch), bit1 = `sw_in2`, bit0 = `sw_in1`.
- R5: The first complete transfer after reset reports bit4 = 1 (supply-loss marker). That marker clears once that transfer completes.
- R6: A fault flag is set while its input is high. A complete transfer clears the flag only if the flag was captured as set by that transfer and the input is low when the transfer ends.
- R7: A rising edge on any fault input makes an interrupt pending and records that source. While an interrupt is pending, bit7 reads 1 and bits 6..2 show the recorded sources, not the live flags. A complete transfer clears the sources it reported.
- R8: Each fault rising edge drives `irq_n` low for exactly IRQ_LEN clock cycles. A new edge restarts the pulse.
- R9: Write bits [1:0] set `mode_bits` as {Mode2, Mode1} (11 normal, 10 normal with watchdog clear, 01 stop, 00 sleep). A write with Mode2 = 1 stores Mode1 as 1.
- R10: Write bits [7:6] select the LIN edge rate (00 standard, 01 slow, 10 fast). The value 11 sets `lowpwr_req` and leaves `lin_slew` unchanged. Any other value clears `lowpwr_req`.
- R11: Write bit5 drives `lin_pullup_off`. Write bits 4, 3 and 2 enable high-side switches 3, 2 and 1. Switches 1 and 2 are on only while `pwm_in` is also high; switch 3 ignores `pwm_in`.
- R12: A high level on `hs_trip[i]` forces `hs_out[i]` off. The switch stays off until a complete transfer writes its enable bit as 1 while the trip input is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| spi_sclk | input | 1 | Serial clock (asynchronous) |
| spi_csn | input | 1 | Chip-select, active low (asynchronous) |
| spi_mosi | input | 1 | Serial data in |
| spi_miso | output | 1 | Serial data out |
| pwm_in | input | 1 | PWM gate for high-side switches 1 and 2 |
| flt_lin | input | 1 | LIN wake or failure event |
| flt_ovolt | input | 1 | Supply over-voltage |
| flt_uvolt | input | 1 | Supply under-voltage |
| flt_regtemp | input | 1 | Regulator temperature warning |
| hs_trip | input | 3 | Per-switch thermal shutdown |
| sw_in1 | input | 1 | Switch-sense input 1 level |
| sw_in2 | input | 1 | Switch-sense input 2 level |
| hs_out | output | 3 | High-side switch drives |
| lin_slew | output | 2 | LIN edge-rate selection |
| lowpwr_req | output | 1 | Low-power entry request |
| lin_pullup_off | output | 1 | Disconnect LIN pull-up in low-power modes |
| mode_bits | output | 2 | Stored {Mode2, Mode1} |
| irq_n | output | 1 | Interrupt pulse, active low |

## Verification
The bench sweeps all 256 write bytes with both PWM levels. This catches a missing Mode1 coercion, a slew field overwritten by the low-power code, or PWM gating applied to switch 3. Each fault source is pulsed on its own and then read twice. A design that shows live flags instead of the recorded sources, or that fails to clear a reported flag, returns the wrong second byte.

A persistent under-voltage exposes a design that clears a flag while its fault is still present. A 7-edge transfer exposes a design that applies or clears on partial transfers. A thermal trip followed by a write with the enable bit at 0 and then at 1 shows whether the shutdown latch releases only on the correct write.

// File: rtl/sbc_ctrl_pkg.sv
package sbc_ctrl_pkg;

    localparam int BYTE_W = 8;
    localparam int NFLT   = 5;
    localparam int NHS    = 3;
    localparam int FL_UV  = 2;

    typedef enum logic [1:0] {
        SLEW_STD    = 2'b00,
        SLEW_SLOW   = 2'b01,
        SLEW_FAST   = 2'b10,
        SLEW_LOWPWR = 2'b11
    } slew_e;

    // write byte, bit 7 down to bit 0
    typedef struct packed {
        slew_e      slew;
        logic       pu_off;
        logic [2:0] hs;
        logic [1:0] mode;
    } wr_word_t;

    // read byte: fl[4]=LIN, fl[3]=over-voltage, fl[2]=under-voltage,
    // fl[1]=regulator temperature, fl[0]=high-side shutdown
    typedef struct packed {
        logic            pend;
        logic [NFLT-1:0] fl;
        logic            l2;
        logic            l1;
    } rd_word_t;

    function automatic rd_word_t make_status(
        input logic [NFLT-1:0] src,
        input logic [NFLT-1:0] flag,
        input logic            batfail,
        input logic            l2,
        input logic            l1
    );
        rd_word_t r;
        r.pend      = |src;
        r.fl        = r.pend ? src : flag;
        r.fl[FL_UV] = r.fl[FL_UV] | batfail;
        r.l2        = l2;
        r.l1        = l1;
        return r;
    endfunction

    function automatic logic [1:0] coerce_mode(input logic [1:0] m);
        return {m[1], m[0] | m[1]};
    endfunction

endpackage

// File: rtl/sbc_spi_sync.sv
module sbc_spi_sync #(
    parameter int STAGES = 2
) (
    input  logic clk,
    input  logic rst,
    input  logic sclk_in,
    input  logic csn_in,
    input  logic mosi_in,
    output logic sclk_rise,
    output logic sclk_fall,
    output logic cs_fall,
    output logic cs_rise,
    output logic cs_act,
    output logic mosi_s
);
    // bit 0 sclk, bit 1 chip-select, bit 2 mosi
    localparam logic [2:0] IDLE = 3'b010;

    logic [2:0] raw;
    logic [2:0] pipe [STAGES];
    logic [1:0] prev;
    logic [2:0] synced;

    assign raw    = {mosi_in, csn_in, sclk_in};
    assign synced = pipe[STAGES-1];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < STAGES; i++) pipe[i] <= IDLE;
            prev <= IDLE[1:0];
        end else begin
            pipe[0] <= raw;
            for (int i = 1; i < STAGES; i++) pipe[i] <= pipe[i-1];
            prev <= synced[1:0];
        end
    end

    assign sclk_rise = synced[0] & ~prev[0];
    assign sclk_fall = ~synced[0] & prev[0];
    assign cs_fall   = ~synced[1] & prev[1];
    assign cs_rise   = synced[1] & ~prev[1];
    assign cs_act    = ~synced[1];
    assign mosi_s    = synced[2];
endmodule

// File: rtl/sbc_spi_shift.sv
module sbc_spi_shift #(
    parameter int W = 8
) (
    input  logic         clk,
    input  logic         rst,
    input  logic         sclk_rise,
    input  logic         sclk_fall,
    input  logic         cs_fall,
    input  logic         cs_rise,
    input  logic         cs_act,
    input  logic         mosi_s,
    input  logic [W-1:0] load_word,
    output logic         miso,
    output logic         done,
    output logic [W-1:0] rx_word
);
    localparam int CW = $clog2(W + 2);
    localparam logic [CW-1:0] SAT = CW'(W + 1);

    logic [W-1:0]  tx;
    logic [CW-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst) begin
            tx      <= '0;
            rx_word <= '0;
            cnt     <= '0;
            miso    <= 1'b0;
        end else if (cs_fall) begin
            tx   <= load_word;
            cnt  <= '0;
            miso <= load_word[W-1];
        end else if (cs_rise) begin
            miso <= 1'b0;
        end else if (cs_act) begin
            if (sclk_rise) begin
                miso <= tx[W-1];
                tx   <= {tx[W-2:0], 1'b0};
            end
            if (sclk_fall) begin
                rx_word <= {rx_word[W-2:0], mosi_s};
                if (cnt != SAT) cnt <= cnt + 1'b1;
            end
        end
    end

    assign done = cs_rise && (cnt == CW'(W));
endmodule

// File: rtl/sbc_fault_track.sv
module sbc_fault_track
    import sbc_ctrl_pkg::*;
#(
    parameter int IRQ_LEN = 16
) (
    input  logic            clk,
    input  logic            rst,
    input  logic [NFLT-1:0] fin,
    input  logic            cap,
    input  logic            done,
    output logic [NFLT-1:0] flag,
    output logic [NFLT-1:0] src,
    output logic            batfail,
    output logic            irq_n
);
    localparam int CW = $clog2(IRQ_LEN + 1);

    logic [NFLT-1:0] fin_q;
    logic [NFLT-1:0] rise;
    logic [NFLT-1:0] snap_flag;
    logic [NFLT-1:0] snap_src;
    logic [CW-1:0]   pulse_cnt;

    assign rise = fin & ~fin_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            fin_q     <= '0;
            flag      <= '0;
            src       <= '0;
            snap_flag <= '0;
            snap_src  <= '0;
            batfail   <= 1'b1;
            pulse_cnt <= '0;
        end else begin
            fin_q <= fin;
            if (cap) begin
                snap_flag <= flag;
                snap_src  <= src;
            end
            if (done) begin
                flag    <= (flag & ~snap_flag) | fin;
                src     <= (src & ~snap_src) | rise;
                batfail <= 1'b0;
            end else begin
                flag <= flag | fin;
                src  <= src | rise;
            end
            if (|rise)               pulse_cnt <= CW'(IRQ_LEN);
            else if (pulse_cnt != 0) pulse_cnt <= pulse_cnt - 1'b1;
        end
    end

    assign irq_n = (pulse_cnt == '0);
endmodule

// File: rtl/sbc_hs_ctrl.sv
module sbc_hs_ctrl
    import sbc_ctrl_pkg::*;
#(
    parameter int PWM_GATED = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_stb,
    input  logic [BYTE_W-1:0] wr_byte,
    input  logic              pwm_in,
    input  logic [NHS-1:0]    hs_trip,
    output logic [NHS-1:0]    hs_out,
    output logic [1:0]        lin_slew,
    output logic              lowpwr_req,
    output logic              pullup_off,
    output logic [1:0]        mode_bits
);
    wr_word_t       w;
    wr_word_t       cfg;
    logic [NHS-1:0] off;

    assign w = wr_word_t'(wr_byte);

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg.slew   <= SLEW_STD;
            cfg.pu_off <= 1'b0;
            cfg.hs     <= '0;
            cfg.mode   <= 2'b11;
            lowpwr_req <= 1'b0;
        end else if (wr_stb) begin
            cfg.mode   <= coerce_mode(w.mode);
            cfg.hs     <= w.hs;
            cfg.pu_off <= w.pu_off;
            if (w.slew == SLEW_LOWPWR) begin
                lowpwr_req <= 1'b1;
            end else begin
                cfg.slew   <= w.slew;
                lowpwr_req <= 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NHS; i++) begin : g_sw
        always_ff @(posedge clk) begin
            if (rst)                     off[i] <= 1'b0;
            else if (hs_trip[i])         off[i] <= 1'b1;
            else if (wr_stb && w.hs[i])  off[i] <= 1'b0;
        end
        if (i < PWM_GATED) begin : g_pwm
            assign hs_out[i] = cfg.hs[i] & ~off[i] & pwm_in;
        end else begin : g_direct
            assign hs_out[i] = cfg.hs[i] & ~off[i];
        end
    end

    assign lin_slew   = cfg.slew;
    assign pullup_off = cfg.pu_off;
    assign mode_bits  = cfg.mode;
endmodule

// File: rtl/sbc_ctrl_port.sv
module sbc_ctrl_port
    import sbc_ctrl_pkg::*;
#(
    parameter int SYNC_STAGES = 2,
    parameter int IRQ_LEN     = 16
) (
    input  logic       clk,
    input  logic       rst,
    input  logic       spi_sclk,
    input  logic       spi_csn,
    input  logic       spi_mosi,
    output logic       spi_miso,
    input  logic       pwm_in,
    input  logic       flt_lin,
    input  logic       flt_ovolt,
    input  logic       flt_uvolt,
    input  logic       flt_regtemp,
    input  logic [2:0] hs_trip,
    input  logic       sw_in1,
    input  logic       sw_in2,
    output logic [2:0] hs_out,
    output logic [1:0] lin_slew,
    output logic       lowpwr_req,
    output logic       lin_pullup_off,
    output logic [1:0] mode_bits,
    output logic       irq_n
);
    logic sclk_rise, sclk_fall, cs_fall, cs_rise, cs_act, mosi_s;
    logic xfer_done;
    logic [BYTE_W-1:0] rx_word;
    logic [NFLT-1:0]   fin, flag, src;
    logic              batfail;
    rd_word_t          stat_now;

    assign fin      = {flt_lin, flt_ovolt, flt_uvolt, flt_regtemp, |hs_trip};
    assign stat_now = make_status(src, flag, batfail, sw_in2, sw_in1);

    sbc_spi_sync #(.STAGES(SYNC_STAGES)) u_sync (
        .clk(clk), .rst(rst),
        .sclk_in(spi_sclk), .csn_in(spi_csn), .mosi_in(spi_mosi),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s)
    );

    sbc_spi_shift #(.W(BYTE_W)) u_shift (
        .clk(clk), .rst(rst),
        .sclk_rise(sclk_rise), .sclk_fall(sclk_fall),
        .cs_fall(cs_fall), .cs_rise(cs_rise), .cs_act(cs_act), .mosi_s(mosi_s),
        .load_word(stat_now), .miso(spi_miso), .done(xfer_done), .rx_word(rx_word)
    );

    sbc_fault_track #(.IRQ_LEN(IRQ_LEN)) u_flt (
        .clk(clk), .rst(rst), .fin(fin), .cap(cs_fall), .done(xfer_done),
        .flag(flag), .src(src), .batfail(batfail), .irq_n(irq_n)
    );

    sbc_hs_ctrl #(.PWM_GATED(2)) u_hs (
        .clk(clk), .rst(rst), .wr_stb(xfer_done), .wr_byte(rx_word),
        .pwm_in(pwm_in), .hs_trip(hs_trip), .hs_out(hs_out),
        .lin_slew(lin_slew), .lowpwr_req(lowpwr_req),
        .pullup_off(lin_pullup_off), .mode_bits(mode_bits)
    );
endmodule

// File: rtl/sbc_ctrl_chk.sv
module sbc_ctrl_chk (
    input logic       clk,
    input logic       rst,
    input logic       xfer_done,
    input logic [1:0] mode_bits,
    input logic [1:0] lin_slew,
    input logic       lowpwr_req,
    input logic       lin_pullup_off,
    input logic       pwm_in,
    input logic [2:0] hs_trip,
    input logic [2:0] hs_out
);
    // R9
    mode_coerce_chk: assert property (@(posedge clk) disable iff (rst)
        mode_bits[1] |-> mode_bits[0]);

    // R10
    slew_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        (!$stable(lin_slew) || !$stable(lowpwr_req)) |-> $past(xfer_done));

    // R11
    pullup_write_only_chk: assert property (@(posedge clk) disable iff (rst)
        !$stable(lin_pullup_off) |-> $past(xfer_done));

    // R11
    pwm_gate_chk: assert property (@(posedge clk) disable iff (rst)
        (hs_out[0] || hs_out[1]) |-> pwm_in);

    for (genvar i = 0; i < 3; i++) begin : g_trip
        // R12
        hs_trip_off_chk: assert property (@(posedge clk) disable iff (rst)
            hs_trip[i] |=> !hs_out[i]);
    end
endmodule

bind sbc_ctrl_port sbc_ctrl_chk u_chk (
    .clk(clk), .rst(rst), .xfer_done(xfer_done), .mode_bits(mode_bits),
    .lin_slew(lin_slew), .lowpwr_req(lowpwr_req), .lin_pullup_off(lin_pullup_off),
    .pwm_in(pwm_in), .hs_trip(hs_trip), .hs_out(hs_out)
);

// File: tb/sim_sbc_ctrl_port.sv
`timescale 1ns/1ps
module sim_sbc_ctrl_port;
    localparam int IRQ_LEN = 16;
    localparam int HALF    = 8;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic spi_sclk = 1'b0, spi_csn = 1'b1, spi_mosi = 1'b0;
    logic spi_miso;
    logic pwm_in = 1'b1;
    logic flt_lin = 0, flt_ovolt = 0, flt_uvolt = 0, flt_regtemp = 0;
    logic [2:0] hs_trip = '0;
    logic sw_in1 = 0, sw_in2 = 0;
    logic [2:0] hs_out;
    logic [1:0] lin_slew, mode_bits;
    logic lowpwr_req, lin_pullup_off, irq_n;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    sbc_ctrl_port #(.SYNC_STAGES(2), .IRQ_LEN(IRQ_LEN)) u0 (
        .clk(clk), .rst(rst), .spi_sclk(spi_sclk), .spi_csn(spi_csn),
        .spi_mosi(spi_mosi), .spi_miso(spi_miso), .pwm_in(pwm_in),
        .flt_lin(flt_lin), .flt_ovolt(flt_ovolt), .flt_uvolt(flt_uvolt),
        .flt_regtemp(flt_regtemp), .hs_trip(hs_trip), .sw_in1(sw_in1),
        .sw_in2(sw_in2), .hs_out(hs_out), .lin_slew(lin_slew),
        .lowpwr_req(lowpwr_req), .lin_pullup_off(lin_pullup_off),
        .mode_bits(mode_bits), .irq_n(irq_n)
    );

    task automatic check(input string req, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic spi_xfer(input logic [7:0] wr, input int nbits, output logic [7:0] rd);
        rd = '0;
        @(negedge clk) spi_csn = 1'b0;
        repeat (HALF) @(negedge clk);
        for (int b = 0; b < nbits; b++) begin
            spi_sclk = 1'b1;
            spi_mosi = wr[7-b];
            repeat (HALF) @(negedge clk);
            rd[7-b] = spi_miso;
            spi_sclk = 1'b0;
            repeat (HALF) @(negedge clk);
        end
        spi_csn = 1'b1;
        repeat (12) @(negedge clk);
    endtask

    task automatic set_fault(input int k, input logic v);
        case (k)
            4: flt_lin     = v;
            3: flt_ovolt   = v;
            2: flt_uvolt   = v;
            1: flt_regtemp = v;
            default: hs_trip[0] = v;
        endcase
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1;
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog: actual=expired expected=done");
        finish_run();
    end

    initial begin
        logic [7:0] rd;
        logic [1:0] exp_slew;
        logic [1:0] exp_mode;

        repeat (5) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R1 reset state
        check("R1 mode", mode_bits, 2'b11);
        check("R1 slew", lin_slew, 2'b00);
        check("R1 lowpwr", lowpwr_req, 0);
        check("R1 pullup", lin_pullup_off, 0);
        check("R1 hs", hs_out, 0);
        check("R1 irq", irq_n, 1);
        check("R1 miso", spi_miso, 0);

        // R5 supply-loss marker on first read, then gone
        spi_xfer(8'h03, 8, rd);
        check("R5 first read", rd, 8'h10);
        spi_xfer(8'h03, 8, rd);
        check("R5 second read", rd, 8'h00);

        // R4 switch-sense bits
        for (int s = 0; s < 4; s++) begin
            sw_in1 = s[0];
            sw_in2 = s[1];
            spi_xfer(8'h03, 8, rd);
            check("R4 sense bits", rd, {6'b0, s[1:0]});
        end
        sw_in1 = 0;
        sw_in2 = 0;

        // R9 R10 R11 sweep over every write byte
        exp_slew = 2'b00;
        for (int v = 0; v < 256; v++) begin
            logic [7:0] wb;
            wb = v[7:0];
            pwm_in = 1'b1;
            spi_xfer(wb, 8, rd);
            check("R3 R4 idle status", rd, 8'h00);
            if (wb[7:6] != 2'b11) exp_slew = wb[7:6];
            exp_mode = {wb[1], wb[0] | wb[1]};
            check("R9 mode", mode_bits, exp_mode);
            check("R10 slew", lin_slew, exp_slew);
            check("R10 lowpwr", lowpwr_req, wb[7:6] == 2'b11);
            check("R11 pullup", lin_pullup_off, wb[5]);
            check("R11 hs pwm high", hs_out, wb[4:2]);
            @(negedge clk) pwm_in = 1'b0;
            #1 check("R11 hs pwm low", hs_out, {wb[4], 2'b00});
            pwm_in = 1'b1;
        end
        spi_xfer(8'h03, 8, rd);

        // R7 R8 R6 each fault source alone
        for (int k = 0; k < 5; k++) begin
            @(negedge clk) set_fault(k, 1'b1);
            @(posedge clk) #1 check("R8 irq low at start", irq_n, 0);
            repeat (IRQ_LEN - 1) @(posedge clk);
            #1 check("R8 irq low at end", irq_n, 0);
            @(posedge clk) #1 check("R8 irq released", irq_n, 1);
            @(negedge clk) set_fault(k, 1'b0);
            spi_xfer(8'h03, 8, rd);
            check("R7 source read", rd, 8'h80 | (8'h04 << k));
            spi_xfer(8'h03, 8, rd);
            check("R6 cleared after read", rd, 8'h00);
        end

        // R7 two sources gathered
        @(negedge clk) flt_ovolt = 1;
        @(negedge clk) flt_ovolt = 0;
        repeat (4) @(negedge clk);
        flt_regtemp = 1;
        @(negedge clk) flt_regtemp = 0;
        spi_xfer(8'h03, 8, rd);
        check("R7 two sources", rd, 8'hA8);

        // R6 persistent under-voltage
        @(negedge clk) flt_uvolt = 1;
        spi_xfer(8'h03, 8, rd);
        check("R7 uv source", rd, 8'h90);
        spi_xfer(8'h03, 8, rd);
        check("R6 uv still present", rd, 8'h10);
        flt_uvolt = 0;
        spi_xfer(8'h03, 8, rd);
        check("R6 uv read once more", rd, 8'h10);
        spi_xfer(8'h03, 8, rd);
        check("R6 uv cleared", rd, 8'h00);

        // R2 partial transfer ignored
        @(negedge clk) flt_ovolt = 1;
        @(negedge clk) flt_ovolt = 0;
        spi_xfer(8'h00, 7, rd);
        check("R2 partial mode kept", mode_bits, 2'b11);
        check("R2 partial status bits", rd[7:1], 7'h50);
        spi_xfer(8'h03, 8, rd);
        check("R2 partial no clear", rd, 8'hA0);

        // R12 thermal latch
        spi_xfer(8'h1F, 8, rd);
        check("R12 all on", hs_out, 3'b111);
        @(negedge clk) hs_trip[1] = 1;
        repeat (3) @(negedge clk);
        hs_trip[1] = 0;
        @(negedge clk);
        check("R12 hs2 tripped", hs_out, 3'b101);
        spi_xfer(8'h17, 8, rd);
        check("R12 HSst source", rd, 8'h84);
        check("R12 enable 0 keeps off", hs_out, 3'b101);
        spi_xfer(8'h1F, 8, rd);
        check("R12 flag cleared", rd, 8'h00);
        check("R12 rewrite restores", hs_out, 3'b111);
        @(negedge clk) hs_trip[2] = 1;
        @(negedge clk) hs_trip[2] = 0;
        @(negedge clk) check("R12 hs3 tripped", hs_out, 3'b011);
        pwm_in = 0;
        #1 check("R11 hs3 ignores pwm", hs_out, 3'b000);
        pwm_in = 1;
        spi_xfer(8'h1F, 8, rd);
        check("R12 hs3 source", rd, 8'h84);
        check("R12 hs3 restored", hs_out, 3'b111);

        finish_run();
    end
endmodule